// File: doc/BRIEF.md
# Multiprocessor Serial Receiver with Address Filter

This block receives asynchronous serial frames with 8 or 9 data bits, sampling a 16x oversampled line. A hardware address filter decides whether each completed frame is delivered. When filtering is enabled, only frames that carry a matching address raise the receive-complete flag. A node on a shared multi-drop line therefore sees only the address frames meant for it, or meant for every node. It does not have to inspect each byte that passes.

Software configures two registers: its own address and a mask that marks which address bits count. From these two values the filter builds a *given* pattern, which selects one node or a chosen group of nodes. It also builds a *broadcast* pattern that reaches all nodes. A sticky framing-error flag records any frame whose stop bit samples low. It shares one status bit position with a general mode bit, and a select input chooses which of the two that position reads and writes.

Top module: `mp_serial_rx`

## Requirements
- R1: After reset, `rxFlag`, `rxData`, `rxBit9`, the framing-error flag and the mode bit are all 0.
- R2: A falling edge on the line is confirmed as a start bit only if the line is still low at the 8th oversample tick. Shorter low pulses are ignored. Data bits are sampled at bit centre, least significant bit first. Mode encoding on `modeSel`: 0 means receiver off, 1 means 8-bit frames, 2 and 3 mean 9-bit frames. In 8-bit frames the stop bit level is stored in `rxBit9`. In 9-bit frames the ninth data bit is stored there.
- R3: With `filtEn` = 0, every completed frame loads `rxData`/`rxBit9` and sets `rxFlag`, provided the flag was clear.
- R4: In 9-bit modes with `filtEn` = 1, a frame is delivered only when its ninth bit is 1 and its payload hits the given or the broadcast pattern.
- R5: In 8-bit mode with `filtEn` = 1, a frame is delivered only when its stop bit is high and its payload hits the given or the broadcast pattern.
- R6: A given hit means the payload equals `slaveAddr` in every bit position where `addrMask` is 1. With address 1100_0000 and mask 1111_1101, the payloads 1100_0000 and 1100_0010 hit and 1100_0001 does not.
- R7: A broadcast hit means the payload is 1 in every bit position where `slaveAddr | addrMask` is 1. An all-zero mask makes every payload hit.
- R8: A frame rejected by the filter leaves `rxData`, `rxBit9` and `rxFlag` unchanged.
- R9: A frame that completes while `rxFlag` is 1 is dropped, and the registers keep the earlier frame.
- R10: A stop bit sampled low sets the framing-error flag in any active mode. The flag stays set across later good frames. Only a status write made with `flagSel` = 1 changes it.
- R11: The status position reads the framing-error flag when `flagSel` = 1 and the mode bit when `flagSel` = 0. A write (`statWe`) changes only the register that is currently selected.
- R12: With `modeSel` = 0 the receiver ignores the line, whatever `filtEn` is: no flag is raised and no data is loaded.
- R13: A pulse on `rxFlagClr` clears `rxFlag` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxLine | input | 1 | Serial input line, idle high |
| baudTick | input | 1 | One pulse per oversample period (16 per bit) |
| modeSel | input | 2 | 0 off, 1 8-bit frames, 2/3 9-bit frames |
| filtEn | input | 1 | Address filter enable |
| slaveAddr | input | 8 | Own node address |
| addrMask | input | 8 | Address bit-significance mask |
| flagSel | input | 1 | Status position select: 1 framing error, 0 mode bit |
| statWe | input | 1 | Status position write strobe |
| statWd | input | 1 | Status position write data |
| rxFlagClr | input | 1 | Receive flag clear strobe |
| rxData | output | 8 | Last delivered payload |
| rxBit9 | output | 1 | Last delivered ninth bit (stop bit in 8-bit mode) |
| rxFlag | output | 1 | Receive-complete flag |
| statusBit | output | 1 | Shared status position read value |

## Verification
The filter is swept over all 256 payloads under two address and mask settings, one in a 9-bit mode and one in 8-bit mode. The ninth bit and the stop bit are varied along the way. A design that confused the two patterns, swapped the AND and OR forms, or ignored the ninth-bit or stop-bit qualifier would let some rejected payloads through, or hold back some hits. Other directed frames target the remaining behaviours. A short low glitch must not start a frame. A frame arriving while the flag is set must not overwrite the held data. A good frame must not clear the framing-error flag. A write must land only in the register that the select picks. Receiver-off mode must drop frames even with the filter disabled.

// File: rtl/mprx_pkg.sv
package mprx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2,
    RX_STOP  = 2'd3
  } rxState_t;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_8BIT = 2'd1,
    MODE_9A   = 2'd2,
    MODE_9B   = 2'd3
  } rxMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;   // sample the line into the shifter
    logic frameEnd;  // stop bit sample point: evaluate frame
  } rxStrobe_t;

endpackage

// File: rtl/mprx_addr_match.sv
module mprx_addr_match #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] payload,
  input  logic [DATA_W-1:0] ownAddr,
  input  logic [DATA_W-1:0] addrMask,
  output logic              givenHit,
  output logic              bcastHit
);

  logic [DATA_W-1:0] givenOk;
  logic [DATA_W-1:0] bcastOk;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    // mask bit 0 means don't-care for the given pattern
    assign givenOk[i] = !addrMask[i] || (payload[i] == ownAddr[i]);
    // broadcast pattern bit 1 demands a 1 in the payload
    assign bcastOk[i] = !(ownAddr[i] | addrMask[i]) || payload[i];
  end

  assign givenHit = &givenOk;
  assign bcastHit = &bcastOk;

endmodule

// File: rtl/mprx_ctrl.sv
module mprx_ctrl
  import mprx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baudTick,
  input  logic       lineS,
  input  logic [1:0] modeSel,
  output rxStrobe_t  strb
);

  localparam int CNT_W  = $clog2(OSR);
  localparam int BCNT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0]  MID_CNT  = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0]  LAST_CNT = CNT_W'(OSR - 1);

  rxState_t          state;
  logic [CNT_W-1:0]  tickCnt;
  logic [BCNT_W-1:0] bitCnt;
  logic              nineBit;
  logic [BCNT_W-1:0] lastBit;
  logic              active;

  assign active  = (rxMode_t'(modeSel) != MODE_OFF);
  assign nineBit = modeSel[1];
  assign lastBit = nineBit ? BCNT_W'(DATA_W) : BCNT_W'(DATA_W - 1);

  always_comb begin
    strb = '0;
    if (baudTick && tickCnt == LAST_CNT) begin
      strb.shiftIn  = (state == RX_BITS);
      strb.frameEnd = (state == RX_STOP);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= RX_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else if (!active) begin
      state   <= RX_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else if (baudTick) begin
      case (state)
        RX_IDLE: begin
          tickCnt <= '0;
          if (!lineS) state <= RX_START;
        end
        RX_START: begin
          if (tickCnt == MID_CNT) begin
            tickCnt <= '0;
            bitCnt  <= '0;
            state   <= lineS ? RX_IDLE : RX_BITS;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        RX_BITS: begin
          if (tickCnt == LAST_CNT) begin
            tickCnt <= '0;
            bitCnt  <= bitCnt + 1'b1;
            if (bitCnt == lastBit) state <= RX_STOP;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (tickCnt == LAST_CNT) begin
            tickCnt <= '0;
            state   <= RX_IDLE;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  // R2
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.shiftIn, strb.frameEnd}));

  // R12
  off_stays_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'd0) |=> (state == RX_IDLE && !strb.frameEnd));

endmodule

// File: rtl/mprx_dp.sv
module mprx_dp
  import mprx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic [1:0]        modeSel,
  input  logic              filtEn,
  input  logic [DATA_W-1:0] slaveAddr,
  input  logic [DATA_W-1:0] addrMask,
  input  logic              flagSel,
  input  logic              statWe,
  input  logic              statWd,
  input  logic              rxFlagClr,
  input  rxStrobe_t         strb,
  output logic              lineS,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit9,
  output logic              rxFlag,
  output logic              statusBit
);

  localparam int SR_W = DATA_W + 1;

  logic [1:0]        syncQ;
  logic [SR_W-1:0]   shiftReg;
  logic              nineBit;
  logic [DATA_W-1:0] payload;
  logic              ninth;
  logic              qualifier;
  logic              givenHit;
  logic              bcastHit;
  logic              accept;
  logic              loadFrame;
  logic              feSet;
  logic              feFlag;
  logic              modeBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], rxLine};
  end
  assign lineS = syncQ[1];

  // LSB first: new bits enter at the top
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shiftReg <= '0;
    else if (strb.shiftIn) shiftReg <= {lineS, shiftReg[SR_W-1:1]};
  end

  assign nineBit = modeSel[1];
  // at frameEnd lineS is the stop bit sample
  assign payload   = nineBit ? shiftReg[DATA_W-1:0] : shiftReg[SR_W-1:1];
  assign ninth     = nineBit ? shiftReg[SR_W-1] : lineS;
  assign qualifier = nineBit ? shiftReg[SR_W-1] : lineS;

  mprx_addr_match #(.DATA_W(DATA_W)) match_i (
    .payload (payload),
    .ownAddr (slaveAddr),
    .addrMask(addrMask),
    .givenHit(givenHit),
    .bcastHit(bcastHit)
  );

  assign accept    = !filtEn || (qualifier && (givenHit || bcastHit));
  assign loadFrame = strb.frameEnd && accept && !rxFlag;
  assign feSet     = strb.frameEnd && !lineS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData <= '0;
      rxBit9 <= 1'b0;
    end else if (loadFrame) begin
      rxData <= payload;
      rxBit9 <= ninth;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rxFlag <= 1'b0;
    else if (loadFrame) rxFlag <= 1'b1;
    else if (rxFlagClr) rxFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    feFlag <= 1'b0;
    else if (feSet)               feFlag <= 1'b1;
    else if (statWe && flagSel)   feFlag <= statWd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    modeBit <= 1'b0;
    else if (statWe && !flagSel)  modeBit <= statWd;
  end

  assign statusBit = flagSel ? feFlag : modeBit;

  // R9
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxFlag |=> ($stable(rxData) && $stable(rxBit9)));

  // R10
  fe_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (feFlag && !(statWe && flagSel)) |=> feFlag);

  // R11
  mode_bit_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!statWe || flagSel) |=> $stable(modeBit));

  // R13
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxFlag && rxFlagClr) |=> !rxFlag);

  // R5
  bad_stop_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.frameEnd && !nineBit && filtEn && !lineS && !rxFlag) |=> !rxFlag);

endmodule

// File: rtl/mp_serial_rx.sv
module mp_serial_rx
  import mprx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic              baudTick,
  input  logic [1:0]        modeSel,
  input  logic              filtEn,
  input  logic [DATA_W-1:0] slaveAddr,
  input  logic [DATA_W-1:0] addrMask,
  input  logic              flagSel,
  input  logic              statWe,
  input  logic              statWd,
  input  logic              rxFlagClr,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit9,
  output logic              rxFlag,
  output logic              statusBit
);

  rxStrobe_t strb;
  logic      lineS;

  mprx_ctrl #(.OSR(OSR), .DATA_W(DATA_W)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .baudTick(baudTick),
    .lineS   (lineS),
    .modeSel (modeSel),
    .strb    (strb)
  );

  mprx_dp #(.DATA_W(DATA_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .rxLine   (rxLine),
    .modeSel  (modeSel),
    .filtEn   (filtEn),
    .slaveAddr(slaveAddr),
    .addrMask (addrMask),
    .flagSel  (flagSel),
    .statWe   (statWe),
    .statWd   (statWd),
    .rxFlagClr(rxFlagClr),
    .strb     (strb),
    .lineS    (lineS),
    .rxData   (rxData),
    .rxBit9   (rxBit9),
    .rxFlag   (rxFlag),
    .statusBit(statusBit)
  );

endmodule

// File: tb/mp_serial_rx_tb_top.sv
`timescale 1ns/1ps
module mp_serial_rx_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxLine = 1'b1;
  logic       baudTick = 1'b1;
  logic [1:0] modeSel = 2'd1;
  logic       filtEn = 1'b0;
  logic [7:0] slaveAddr = 8'h00;
  logic [7:0] addrMask = 8'h00;
  logic       flagSel = 1'b0;
  logic       statWe = 1'b0;
  logic       statWd = 1'b0;
  logic       rxFlagClr = 1'b0;
  logic [7:0] rxData;
  logic       rxBit9;
  logic       rxFlag;
  logic       statusBit;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] expData;
  logic       expB9;

  always #10 clk = ~clk;

  mp_serial_rx dut_i (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .baudTick(baudTick),
    .modeSel(modeSel), .filtEn(filtEn), .slaveAddr(slaveAddr),
    .addrMask(addrMask), .flagSel(flagSel), .statWe(statWe),
    .statWd(statWd), .rxFlagClr(rxFlagClr), .rxData(rxData),
    .rxBit9(rxBit9), .rxFlag(rxFlag), .statusBit(statusBit)
  );

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic holdBit(input logic v);
    rxLine = v;
    repeat (16) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic nine, input logic b9, input logic stopV);
    @(negedge clk);
    holdBit(1'b0);
    for (int i = 0; i < 8; i++) holdBit(d[i]);
    if (nine) holdBit(b9);
    holdBit(stopV);
    rxLine = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  task automatic clearFlag();
    @(negedge clk); rxFlagClr = 1'b1;
    @(negedge clk); rxFlagClr = 1'b0;
  endtask

  task automatic writeStatus(input logic sel, input logic v);
    @(negedge clk); flagSel = sel; statWd = v; statWe = 1'b1;
    @(negedge clk); statWe = 1'b0;
  endtask

  function automatic logic hitsAddr(input logic [7:0] d, input logic [7:0] sa, input logic [7:0] m);
    logic [7:0] bc;
    bc = sa | m;
    return (((d ^ sa) & m) == 8'h00) || ((d & bc) == bc);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rxFlag", rxFlag, 0);
    check("R1 rxData", rxData, 0);
    check("R1 rxBit9", rxBit9, 0);
    flagSel = 1'b1; @(negedge clk);
    check("R1 fe flag", statusBit, 0);
    flagSel = 1'b0; @(negedge clk);
    check("R1 mode bit", statusBit, 0);

    // R3 / R2: unfiltered 8-bit and 9-bit frames
    modeSel = 2'd1; filtEn = 1'b0;
    sendFrame(8'hA5, 1'b0, 1'b0, 1'b1);
    check("R3 flag 8-bit", rxFlag, 1);
    check("R2 data 8-bit", rxData, 9'h0A5);
    check("R2 stop into ninth", rxBit9, 1);
    clearFlag();
    check("R13 flag cleared", rxFlag, 0);
    modeSel = 2'd2;
    sendFrame(8'h3C, 1'b1, 1'b0, 1'b1);
    check("R3 flag 9-bit", rxFlag, 1);
    check("R2 data 9-bit", rxData, 9'h03C);
    check("R2 ninth bit", rxBit9, 0);
    clearFlag();

    // R2 glitch shorter than half a bit
    @(negedge clk); rxLine = 1'b0;
    repeat (3) @(negedge clk); rxLine = 1'b1;
    repeat (300) @(negedge clk);
    check("R2 glitch ignored", rxFlag, 0);
    check("R2 glitch data", rxData, 9'h03C);

    // R4 / R6 / R7 / R8 sweep, 9-bit mode
    expData = 8'h3C; expB9 = 1'b0;
    modeSel = 2'd2; filtEn = 1'b1; slaveAddr = 8'hC0; addrMask = 8'hFD;
    for (int d = 0; d < 256; d++) begin
      logic b9, acc;
      b9  = (d % 5) != 0;
      acc = b9 && hitsAddr(8'(d), slaveAddr, addrMask);
      sendFrame(8'(d), 1'b1, b9, 1'b1);
      if (acc) begin expData = 8'(d); expB9 = b9; end
      check("R4/R6/R7 flag", rxFlag, 9'(acc));
      check("R8 data", rxData, 9'(expData));
      check("R8 ninth", rxBit9, 9'(expB9));
      if (rxFlag) clearFlag();
    end
    // R6 example points (d%5 != 0 for these, so ninth bit was 1)
    check("R6 example C0", 9'(hitsAddr(8'hC0, 8'hC0, 8'hFD)), 1);
    check("R6 example C1", 9'(hitsAddr(8'hC1, 8'hC0, 8'hFD)), 0);

    // R5 / R7 / R10 sweep, 8-bit mode
    modeSel = 2'd1; slaveAddr = 8'h12; addrMask = 8'hF0;
    for (int d = 0; d < 256; d++) begin
      logic stp, acc;
      stp = (d % 7) != 0;
      acc = stp && hitsAddr(8'(d), slaveAddr, addrMask);
      sendFrame(8'(d), 1'b0, 1'b0, stp);
      if (acc) begin expData = 8'(d); expB9 = 1'b1; end
      check("R5/R7 flag", rxFlag, 9'(acc));
      check("R8 data 8-bit", rxData, 9'(expData));
      flagSel = 1'b1; @(negedge clk);
      check("R10 fe on bad stop", statusBit, 9'(!stp));
      if (!stp) writeStatus(1'b1, 1'b0);
      flagSel = 1'b0;
      if (rxFlag) clearFlag();
    end

    // R7 all-zero mask matches anything
    slaveAddr = 8'h5A; addrMask = 8'h00;
    for (int k = 0; k < 3; k++) begin
      logic [7:0] v;
      v = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'h33;
      sendFrame(v, 1'b0, 1'b0, 1'b1);
      check("R7 zero mask flag", rxFlag, 1);
      check("R7 zero mask data", rxData, 9'(v));
      clearFlag();
    end

    // R9 frame dropped while flag set
    filtEn = 1'b0;
    sendFrame(8'h11, 1'b0, 1'b0, 1'b1);
    sendFrame(8'h22, 1'b0, 1'b0, 1'b1);
    check("R9 flag kept", rxFlag, 1);
    check("R9 data kept", rxData, 9'h011);
    clearFlag();

    // R10 / R11 framing error sticky, shared status position
    modeSel = 2'd3;
    sendFrame(8'h44, 1'b1, 1'b1, 1'b0);
    flagSel = 1'b1; @(negedge clk);
    check("R10 fe set 9-bit", statusBit, 1);
    clearFlag();
    sendFrame(8'h45, 1'b1, 1'b1, 1'b1);
    check("R10 good frame delivered", rxData, 9'h045);
    check("R10 fe still set", statusBit, 1);
    clearFlag();
    flagSel = 1'b0; @(negedge clk);
    check("R11 mode bit view", statusBit, 0);
    writeStatus(1'b0, 1'b1);
    check("R11 mode bit written", statusBit, 1);
    flagSel = 1'b1; @(negedge clk);
    check("R11 fe untouched by mode write", statusBit, 1);
    writeStatus(1'b1, 1'b0);
    check("R10 fe cleared by write", statusBit, 0);
    flagSel = 1'b0; @(negedge clk);
    check("R11 mode bit untouched", statusBit, 1);

    // R12 receiver off
    modeSel = 2'd0;
    for (int f = 0; f < 2; f++) begin
      filtEn = f[0];
      sendFrame(8'h99, 1'b0, 1'b0, 1'b1);
      check("R12 no flag when off", rxFlag, 0);
      check("R12 data unchanged", rxData, 9'h045);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule